// File: doc/BRIEF.md
# Inter-processor mailbox flag controller

This block lets two processors signal each other about messages they keep in a shared memory outside the block. For each direction it keeps one flag per channel, and six channels are built by default. A flag at 1 means the slot is occupied: the sender has posted a message and the receiver has not yet consumed it. A flag at 0 means the slot is free. The sender raises a flag with a one-shot command write. Only the receiver can drop that flag again, also with a one-shot command.

Each processor has its own bank of four word registers: a control word with two interrupt enables, a mask word, a command word and a read-only status word. Processor 1's bank starts at 0x000 and processor 2's bank starts at 0x010. From the flags, masks and enables the block drives two level interrupts to each processor. The TX-free interrupt tells a sender that one of its unmasked outgoing slots is free. The RX-occupied interrupt tells a receiver that one of its unmasked incoming slots holds a message.

Access uses a simple 32-bit register bus that carries a requester identifier. A processor may read every register, but it can change only the registers in its own bank.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset every flag is 0, both control words read 0x00000000, both mask words read 0x003F003F, and all four interrupts are low.
- R2: A word write by processor p to its command word (0x008 for p1, 0x018 for p2) sets channel n of p's outgoing flags for every 1 in bit 16+n. Bits written as 0 leave the flags unchanged. p1's outgoing flags read at 0x00C and p2's at 0x01C, in bits 5:0.
- R3: In the same command write, every 1 in bit n clears channel n of p's incoming flags, which are the other processor's outgoing flags. Bits written as 0 leave the flags unchanged.
- R4: Both command words always read 0x00000000.
- R5: The mask word (0x004 / 0x014) holds the free masks for the outgoing channels in bits 21:16 and the occupied masks for the incoming channels in bits 5:0. A mask bit of 1 masks its channel.
- R6: The control word (0x000 / 0x010) holds the TX-free enable in bit 16 and the RX-occupied enable in bit 0.
- R7: A processor's TX-free interrupt is high exactly when its TX-free enable is 1 and some outgoing channel has flag 0 and free mask 0. The interrupt changes one clock after the state that drives it.
- R8: A processor's RX-occupied interrupt is high exactly when its RX-occupied enable is 1 and some incoming channel has flag 1 and occupied mask 0. The interrupt changes one clock after the state that drives it.
- R9: A write whose size code is not 2'b10 (word) changes no register and no flag.
- R10: Reserved bits read as 0 and ignore writes. Status words ignore writes. Offsets other than the eight registers (including addresses that are not word-aligned) read as 0.
- R11: A write from processor p (requester ID 0 = p1, 1 = p2) into the other processor's bank has no effect. Reads are allowed from either ID.
- R12: Read data appears on bus_rdata on the clock after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_id | input | 1 | Requester: 0 = processor 1, 1 = processor 2 |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size, 2'b10 = word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| p1_tx_free_irq | output | 1 | TX-free interrupt to processor 1 |
| p1_rx_occ_irq | output | 1 | RX-occupied interrupt to processor 1 |
| p2_tx_free_irq | output | 1 | TX-free interrupt to processor 2 |
| p2_rx_occ_irq | output | 1 | RX-occupied interrupt to processor 2 |

## Verification
The bench builds the block with its defaults: six channels per direction and a 12-bit address. With only six channels, every one of the 64 free-mask patterns and every one of the 64 occupied-mask patterns can be swept against fixed flag patterns, and each expected interrupt is computed arithmetically. A long pseudo-random sequence of writes then follows. It mixes requesters, offsets, sizes and reserved bits. After each write the bench compares every register and every interrupt with a model built from the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [1:0] SIZE_WORD = 2'b10;
  localparam int         HI_LSB    = 16;   // free masks, set commands, TX enable
  localparam int         LO_LSB    = 0;    // occupied masks, clear commands, RX enable
  localparam int         NUM_PROC  = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MASK = 2'd1,
    REG_CMD  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 12,
  parameter int PROC   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              tx_en,
  output logic              rx_en,
  output logic [NUM_CH-1:0] free_mask,
  output logic [NUM_CH-1:0] occ_mask,
  output logic [NUM_CH-1:0] set_req,
  output logic [NUM_CH-1:0] clr_req
);
  localparam int BANK_W = ADDR_W - 4;

  logic              wr_hit;
  reg_sel_e          sel;
  logic              tx_en_d, rx_en_d;
  logic [NUM_CH-1:0] free_mask_d, occ_mask_d;

  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign wr_hit = bus_sel && bus_wr && (bus_size == SIZE_WORD)
                  && (bus_id == 1'(PROC))
                  && (bus_addr[ADDR_W-1:4] == BANK_W'(PROC))
                  && (bus_addr[1:0] == 2'b00);

  always_comb begin
    tx_en_d     = tx_en;
    rx_en_d     = rx_en;
    free_mask_d = free_mask;
    occ_mask_d  = occ_mask;
    if (wr_hit) begin
      unique case (sel)
        REG_CTRL: begin
          tx_en_d = bus_wdata[HI_LSB];
          rx_en_d = bus_wdata[LO_LSB];
        end
        REG_MASK: begin
          free_mask_d = bus_wdata[HI_LSB +: NUM_CH];
          occ_mask_d  = bus_wdata[LO_LSB +: NUM_CH];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      free_mask <= '1;
      occ_mask  <= '1;
    end else begin
      tx_en     <= tx_en_d;
      rx_en     <= rx_en_d;
      free_mask <= free_mask_d;
      occ_mask  <= occ_mask_d;
    end
  end

  assign set_req = (wr_hit && sel == REG_CMD) ? bus_wdata[HI_LSB +: NUM_CH] : '0;
  assign clr_req = (wr_hit && sel == REG_CMD) ? bus_wdata[LO_LSB +: NUM_CH] : '0;
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_req,
  input  logic [NUM_CH-1:0] clr_req,
  output logic [NUM_CH-1:0] flag_q
);
  logic [NUM_CH-1:0] flag_d;

  always_comb begin
    flag_d = (flag_q & ~clr_req) | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [NUM_CH-1:0] out_flag,
  input  logic [NUM_CH-1:0] free_mask,
  input  logic [NUM_CH-1:0] in_flag,
  input  logic [NUM_CH-1:0] occ_mask,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic tx_d, rx_d;

  always_comb begin
    tx_d = tx_en && (|(~out_flag & ~free_mask));
    rx_d = rx_en && (|(in_flag & ~occ_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      tx_irq <= tx_d;
      rx_irq <= rx_d;
    end
  end
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              p1_tx_free_irq,
  output logic              p1_rx_occ_irq,
  output logic              p2_tx_free_irq,
  output logic              p2_rx_occ_irq
);
  // Index p: flag_q[p] holds the flags that processor p sends.
  logic [NUM_PROC-1:0][NUM_CH-1:0] flag_q;
  logic [NUM_PROC-1:0][NUM_CH-1:0] free_mask, occ_mask, set_req, clr_req;
  logic [NUM_PROC-1:0]             tx_en, rx_en, tx_irq, rx_irq;

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
    mbx_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PROC(p)) u_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_id(bus_id), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .tx_en(tx_en[p]), .rx_en(rx_en[p]),
      .free_mask(free_mask[p]), .occ_mask(occ_mask[p]),
      .set_req(set_req[p]), .clr_req(clr_req[p])
    );

    mbx_flags #(.NUM_CH(NUM_CH)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_req(set_req[p]), .clr_req(clr_req[NUM_PROC-1-p]),
      .flag_q(flag_q[p])
    );

    mbx_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en[p]), .rx_en(rx_en[p]),
      .out_flag(flag_q[p]), .free_mask(free_mask[p]),
      .in_flag(flag_q[NUM_PROC-1-p]), .occ_mask(occ_mask[p]),
      .tx_irq(tx_irq[p]), .rx_irq(rx_irq[p])
    );
  end

  assign p1_tx_free_irq = tx_irq[0];
  assign p1_rx_occ_irq  = rx_irq[0];
  assign p2_tx_free_irq = tx_irq[1];
  assign p2_rx_occ_irq  = rx_irq[1];

  logic        rd_en;
  logic        rd_bank;
  logic [31:0] rd_d;

  assign rd_en   = bus_sel && !bus_wr;
  assign rd_bank = bus_addr[4];

  always_comb begin
    rd_d = '0;
    if (bus_addr[ADDR_W-1:5] == '0 && bus_addr[1:0] == 2'b00) begin
      unique case (reg_sel_e'(bus_addr[3:2]))
        REG_CTRL: begin
          rd_d[HI_LSB] = tx_en[rd_bank];
          rd_d[LO_LSB] = rx_en[rd_bank];
        end
        REG_MASK: begin
          rd_d[HI_LSB +: NUM_CH] = free_mask[rd_bank];
          rd_d[LO_LSB +: NUM_CH] = occ_mask[rd_bank];
        end
        REG_STAT: rd_d[LO_LSB +: NUM_CH] = flag_q[rd_bank];
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_d;
  end
endmodule

// File: rtl/mbx_flag_ctrl_chk.sv
module mbx_flag_ctrl_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_sel,
  input logic                            bus_wr,
  input logic                            bus_id,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [1:0]                      bus_size,
  input logic [31:0]                     bus_wdata,
  input logic [31:0]                     bus_rdata,
  input logic [NUM_PROC-1:0][NUM_CH-1:0] flag_q,
  input logic [NUM_PROC-1:0][NUM_CH-1:0] free_mask,
  input logic [NUM_PROC-1:0][NUM_CH-1:0] occ_mask,
  input logic [NUM_PROC-1:0]             tx_en,
  input logic [NUM_PROC-1:0]             rx_en,
  input logic                            p1_tx_free_irq,
  input logic                            p2_rx_occ_irq
);
  logic wr_word;
  assign wr_word = bus_sel && bus_wr && (bus_size == SIZE_WORD);

  // R2: p1 command write raises the requested outgoing flags
  a_r2_set_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !bus_id && bus_addr == ADDR_W'(8))
    |=> ((flag_q[0] & $past(bus_wdata[HI_LSB +: NUM_CH])) == $past(bus_wdata[HI_LSB +: NUM_CH])));

  // R3: p2 command write drops the requested incoming flags
  a_r3_clear_by_p2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_id && bus_addr == ADDR_W'(24))
    |=> ((flag_q[0] & $past(bus_wdata[LO_LSB +: NUM_CH])) == '0));

  // R4: command word reads zero
  a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(8)) |=> (bus_rdata == 32'h0));

  // R7: p1 TX-free interrupt follows its inputs one clock later
  a_r7_tx_p1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (p1_tx_free_irq == $past(tx_en[0] && (|(~flag_q[0] & ~free_mask[0])))));

  // R8: p2 RX-occupied interrupt follows its inputs one clock later
  a_r8_rx_p2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (p2_rx_occ_irq == $past(rx_en[1] && (|(flag_q[0] & ~occ_mask[1])))));

  // R9: narrow writes change nothing
  a_r9_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size != SIZE_WORD)
    |=> ($stable(flag_q) && $stable(free_mask) && $stable(occ_mask) && $stable(tx_en) && $stable(rx_en)));

  // R11: p2 writing p1's command word changes no flag
  a_r11_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_id && bus_addr == ADDR_W'(8)) |=> $stable(flag_q));
endmodule

bind mbx_flag_ctrl mbx_flag_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_id(bus_id),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .flag_q(flag_q), .free_mask(free_mask),
  .occ_mask(occ_mask), .tx_en(tx_en), .rx_en(rx_en),
  .p1_tx_free_irq(p1_tx_free_irq), .p2_rx_occ_irq(p2_rx_occ_irq)
);

// File: tb/mbx_flag_ctrl_test.sv
module mbx_flag_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  logic              clk, rst_n;
  logic              bus_sel, bus_wr, bus_id;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              p1_tx, p1_rx, p2_tx, p2_rx;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // model state, index = processor (0 = p1)
  logic [5:0] m_flag [2];
  logic [5:0] m_fm   [2];
  logic [5:0] m_om   [2];
  logic       m_tx   [2];
  logic       m_rx   [2];

  mbx_flag_ctrl #(.NUM_CH(6), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_id(bus_id),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .p1_tx_free_irq(p1_tx), .p1_rx_occ_irq(p1_rx),
    .p2_tx_free_irq(p2_tx), .p2_rx_occ_irq(p2_rx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_flag[p] = '0; m_fm[p] = '1; m_om[p] = '1; m_tx[p] = 0; m_rx[p] = 0;
    end
  endtask

  task automatic model_write(input logic id, input logic [ADDR_W-1:0] a,
                             input logic [1:0] sz, input logic [31:0] d);
    int p;
    if (sz != 2'b10 || a[1:0] != 2'b00 || a >= 12'h020) return;
    p = int'(a[4]);
    if (int'(id) != p) return;
    case (a[3:2])
      2'd0: begin m_tx[p] = d[16]; m_rx[p] = d[0]; end
      2'd1: begin m_fm[p] = d[21:16]; m_om[p] = d[5:0]; end
      2'd2: begin m_flag[p] = m_flag[p] | d[21:16]; m_flag[1-p] = m_flag[1-p] & ~d[5:0]; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
    int p;
    if (a[1:0] != 2'b00 || a >= 12'h020) return 32'h0;
    p = int'(a[4]);
    case (a[3:2])
      2'd0: return {15'h0, m_tx[p], 15'h0, m_rx[p]};
      2'd1: return {10'h0, m_fm[p], 10'h0, m_om[p]};
      2'd3: return {26'h0, m_flag[p]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_write(input logic id, input logic [ADDR_W-1:0] a,
                           input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_id = id; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_write(id, a, sz, d);
  endtask

  task automatic bus_read(input logic id, input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_id = id; bus_addr = a; bus_size = 2'b10;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // flags settle at the write edge; interrupts one edge later
  task automatic check_irqs();
    logic e;
    @(negedge clk);
    e = m_tx[0] && |(~m_flag[0] & ~m_fm[0]);
    check(p1_tx === e, "R7 p1 tx", {31'h0, p1_tx}, {31'h0, e});
    e = m_tx[1] && |(~m_flag[1] & ~m_fm[1]);
    check(p2_tx === e, "R7 p2 tx", {31'h0, p2_tx}, {31'h0, e});
    e = m_rx[0] && |(m_flag[1] & ~m_om[0]);
    check(p1_rx === e, "R8 p1 rx", {31'h0, p1_rx}, {31'h0, e});
    e = m_rx[1] && |(m_flag[0] & ~m_om[1]);
    check(p2_rx === e, "R8 p2 rx", {31'h0, p2_rx}, {31'h0, e});
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d, e;
    for (int i = 0; i < 8; i++) begin
      logic [ADDR_W-1:0] a = ADDR_W'(i * 4);
      bus_read(1'(i % 2), a, d);
      e = model_read(a);
      check(d === e, tag, d, e);
    end
  endtask

  logic [31:0] rd;
  logic [15:0] lfsr;

  initial begin
    bus_sel = 0; bus_wr = 0; bus_id = 0; bus_addr = '0; bus_size = 2'b10; bus_wdata = '0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check({p1_tx, p1_rx, p2_tx, p2_rx} === 4'b0, "R1 irqs", {28'h0, p1_tx, p1_rx, p2_tx, p2_rx}, 32'h0);
    bus_read(0, 12'h004, rd); check(rd === 32'h003F003F, "R1 p1 mask", rd, 32'h003F003F);
    bus_read(1, 12'h014, rd); check(rd === 32'h003F003F, "R1 p2 mask", rd, 32'h003F003F);
    bus_read(0, 12'h000, rd); check(rd === 32'h0, "R1 p1 ctrl", rd, 32'h0);
    bus_read(1, 12'h01C, rd); check(rd === 32'h0, "R1 p2 status", rd, 32'h0);

    // R12: data after the strobe edge, held afterwards
    bus_read(0, 12'h004, rd); check(rd === 32'h003F003F, "R12 read latency", rd, 32'h003F003F);
    @(negedge clk); check(bus_rdata === 32'h003F003F, "R12 read hold", bus_rdata, 32'h003F003F);

    // R2: set channels one at a time from p1, read p1 status
    for (int n = 0; n < 6; n++) begin
      bus_write(0, 12'h008, 2'b10, 32'h1 << (16 + n));
      bus_read(1, 12'h00C, rd);
      check(rd === model_read(12'h00C), "R2 p1 set", rd, model_read(12'h00C));
    end
    // R3: p2 clears alternate channels
    bus_write(1, 12'h018, 2'b10, 32'h0000_0015);
    bus_read(0, 12'h00C, rd); check(rd === 32'h0000_002A, "R3 p2 clear", rd, 32'h2A);
    // R4
    bus_read(0, 12'h008, rd); check(rd === 32'h0, "R4 cmd read", rd, 32'h0);
    // R11: p2 tries to set p1 channels and change p1 masks
    bus_write(1, 12'h008, 2'b10, 32'h003F_003F);
    bus_write(1, 12'h004, 2'b10, 32'h0);
    bus_read(0, 12'h00C, rd); check(rd === 32'h0000_002A, "R11 foreign cmd", rd, 32'h2A);
    bus_read(0, 12'h004, rd); check(rd === 32'h003F003F, "R11 foreign mask", rd, 32'h003F003F);
    // R9: narrow writes
    bus_write(0, 12'h008, 2'b00, 32'h003F_0000);
    bus_write(0, 12'h000, 2'b01, 32'h0001_0001);
    bus_read(0, 12'h00C, rd); check(rd === 32'h0000_002A, "R9 narrow cmd", rd, 32'h2A);
    bus_read(0, 12'h000, rd); check(rd === 32'h0, "R9 narrow ctrl", rd, 32'h0);
    // R10: status write, reserved bits, unmapped and unaligned offsets
    bus_write(0, 12'h00C, 2'b10, 32'hFFFF_FFFF);
    bus_read(0, 12'h00C, rd); check(rd === 32'h0000_002A, "R10 status ro", rd, 32'h2A);
    bus_write(0, 12'h000, 2'b10, 32'hFFFF_FFFF);
    bus_read(0, 12'h000, rd); check(rd === 32'h0001_0001, "R10 ctrl reserved", rd, 32'h00010001);
    bus_read(0, 12'h020, rd); check(rd === 32'h0, "R10 unmapped", rd, 32'h0);
    bus_read(0, 12'h00D, rd); check(rd === 32'h0, "R10 unaligned", rd, 32'h0);
    bus_read(1, 12'h3FC, rd); check(rd === 32'h0, "R10 far offset", rd, 32'h0);

    // R5 R6 R7 R8: exhaustive mask sweeps, both processors' interrupts enabled
    bus_write(0, 12'h000, 2'b10, 32'h0001_0001);
    bus_write(1, 12'h010, 2'b10, 32'h0001_0001);
    bus_write(1, 12'h018, 2'b10, 32'h0015_0000);
    for (int m = 0; m < 64; m++) begin
      bus_write(0, 12'h004, 2'b10, {10'h0, 6'(m), 10'h0, 6'(63 - m)});
      check_irqs();
      bus_read(0, 12'h004, rd);
      check(rd === model_read(12'h004), "R5 mask rw", rd, model_read(12'h004));
    end
    for (int m = 0; m < 64; m++) begin
      bus_write(1, 12'h014, 2'b10, {10'h0, 6'(63 - m), 10'h0, 6'(m)});
      check_irqs();
    end
    // enables off gate both lines
    bus_write(0, 12'h000, 2'b10, 32'h0);
    check_irqs();
    bus_read(0, 12'h000, rd); check(rd === 32'h0, "R6 ctrl off", rd, 32'h0);

    // pseudo-random mix of requesters, offsets, sizes and data
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      logic [ADDR_W-1:0] a;
      logic [1:0]        sz;
      logic [31:0]       d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a  = (lfsr[9:8] == 2'b11) ? ADDR_W'({lfsr[5:2], 2'b00} + 12'h020) : ADDR_W'({lfsr[4:2], 2'b00});
      if (lfsr[15:12] == 4'h0) a[0] = 1'b1;
      sz = (lfsr[11:10] == 2'b00) ? lfsr[1:0] : 2'b10;
      d  = {lfsr, lfsr[7:0] ^ lfsr[15:8], lfsr[15:8]};
      bus_write(lfsr[6], a, sz, d);
      check_irqs();
      if (k % 10 == 0) check_regs("R2 R3 R5 R6 readback");
    end
    check_regs("R10 final readback");

    finish_run();
  end
endmodule